// File: doc/BRIEF.md
# Coherent RTC Time Snapshot Unit

This block holds the calendar and time of a real-time clock in two copies. The counting copy advances once per second and cannot be reached from the bus. The visible copy is the only one that the register port reads and writes. A prescaler divides an oscillator strobe down to the one-second event. With `PRESCALE` set to 1, the strobe can be a ready-made pulse-per-second signal.

A serial bus slave (outside this block) marks each transaction with a start strobe and a stop strobe. In between, it moves bytes through a byte-wide port whose address pointer advances on its own. While a transaction is open, the visible copy is frozen, so a burst over all seven fields returns one instant. The counting copy keeps running during that time, and its value is copied into the visible copy once the transaction closes. Bytes written during a transaction go into a staging copy. At stop, the written fields, and only those, are loaded into both copies at once, and the sub-second phase restarts.

Top module: `rtc_snap_top`

## Requirements
- R1: After reset, the time reads seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00. All fields are BCD.
- R2: Between start and stop, the visible copy does not change. Every byte read in one transaction comes from the same instant, even when a second elapses during the transaction.
- R3: Outside a transaction, the visible copy takes the counting value one cycle later. A rollover can therefore fall between two separate transactions.
- R4: A write strobe outside a transaction is ignored. It changes neither the time nor the address pointer.
- R5: Addresses 0 to 6 select seconds, minutes, hours, weekday, date, month and year, in that order. The pointer advances after every read and every accepted write, and moves from 6 back to 0. Loading address 7 selects 0.
- R6: Seconds and minutes wrap from 59 to 00 with a carry. Hours wrap from 23 to 00 with a carry. The weekday runs 01 to 07 and then returns to 01 when the day changes.
- R7: Seconds that elapse while a transaction is open are not lost. After stop, the visible copy shows the advanced time.
- R8: A transaction that wrote at least one byte commits at stop and restarts the sub-second phase. The next second then follows exactly `PRESCALE` oscillator strobes later.
- R9: The date carries according to month length: 30 days for months 04, 06, 09 and 11, 29 days for month 02 when the year is divisible by 4 (year 00 included), 28 days otherwise for month 02, and 31 days for all other months. Month 12 carries to 01 and increments the year. Year 99 wraps to 00.
- R10: A commit replaces only the fields written in that transaction. Every other field keeps its counting value.
- R11: During a transaction, a read of a field that was just written returns the frozen visible value, not the staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator strobe, divided by PRESCALE to give one second |
| xfer_start | input | 1 | Strobe that opens a bus transaction |
| xfer_stop | input | 1 | Strobe that closes a bus transaction |
| addr_set | input | 1 | Loads the address pointer from addr_in |
| addr_in | input | 3 | Register address to load |
| rd_strobe | input | 1 | Byte read; advances the pointer |
| wr_strobe | input | 1 | Byte write of wr_data at the pointer |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Visible-copy byte at the pointer |

## Verification
The assertions assume that the bus slave never raises start and stop in the same cycle. They also assume that no write strobe coincides with a stop, and that every written byte is a legal BCD value for its field, so the counting copy stays in range. The directed tasks keep to these rules. Each strobe is raised for exactly one cycle, and starts and stops are issued from separate tasks. Every byte written is a valid time or date value, and the only deliberately ignored write occurs with no transaction open.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int FIELD_COUNT = 7;
    localparam int ADDR_W      = $clog2(FIELD_COUNT);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FIELD_COUNT - 1);

    typedef logic [7:0] bcd_t;

    // Field k of the vector lives at bits [8k +: 8]; seconds is field 0.
    typedef logic [FIELD_COUNT-1:0][7:0] time_vec_t;

    typedef struct packed {
        bcd_t year;
        bcd_t month;
        bcd_t date;
        bcd_t wday;
        bcd_t hour;
        bcd_t min;
        bcd_t sec;
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{
        year: 8'h00, month: 8'h01, date: 8'h01, wday: 8'h01,
        hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    function automatic bcd_t bcd_inc(bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible by 4 for two BCD digits: even tens digit with units 0/4/8,
    // or odd tens digit with units 2/6.
    function automatic logic is_leap(bcd_t year);
        if (year[4]) return (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        return (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
    endfunction

    function automatic bcd_t month_last_day(bcd_t month, bcd_t year);
        case (month)
            8'h02:                     return is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                   return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t advance_second(rtc_time_t t);
        rtc_time_t n = t;
        if (t.sec < 8'h59) begin
            n.sec = bcd_inc(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.min < 8'h59) begin
                n.min = bcd_inc(t.min);
            end else begin
                n.min = 8'h00;
                if (t.hour < 8'h23) begin
                    n.hour = bcd_inc(t.hour);
                end else begin
                    n.hour = 8'h00;
                    n.wday = (t.wday >= 8'h07) ? 8'h01 : bcd_inc(t.wday);
                    if (t.date < month_last_day(t.month, t.year)) begin
                        n.date = bcd_inc(t.date);
                    end else begin
                        n.date = 8'h01;
                        if (t.month < 8'h12) begin
                            n.month = bcd_inc(t.month);
                        end else begin
                            n.month = 8'h01;
                            n.year  = (t.year >= 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic logic [ADDR_W-1:0] ptr_next(logic [ADDR_W-1:0] p);
        return (p >= LAST_ADDR) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/rtc_snap_prescaler.sv
module rtc_snap_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic clear,
    output logic sec_pulse,
    output logic phase_zero
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] phase_q;

    assign sec_pulse  = osc_tick && (phase_q == LAST) && !clear;
    assign phase_zero = (phase_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (osc_tick) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_snap_counter.sv
module rtc_snap_counter
    import rtc_snap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_pulse,
    input  logic      load_en,
    input  time_vec_t load_val,
    output time_vec_t cnt_q
);
    rtc_time_t cur;
    rtc_time_t nxt;

    assign cur = rtc_time_t'(cnt_q);
    assign nxt = advance_second(cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= time_vec_t'(RESET_TIME);
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (sec_pulse) begin
            cnt_q <= time_vec_t'(nxt);
        end
    end
endmodule

// File: rtl/rtc_snap_regport.sv
module rtc_snap_regport
    import rtc_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              addr_set,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic [7:0]        wr_data,
    input  time_vec_t         cnt_time,
    output logic [7:0]        rd_data,
    output logic              load_en,
    output time_vec_t         load_val,
    output time_vec_t         vis_q,
    output logic              open_q,
    output logic [ADDR_W-1:0] ptr_q
);
    logic                   wr_take;
    logic [FIELD_COUNT-1:0] mask_q;
    time_vec_t              stage_q;

    assign wr_take = wr_strobe && open_q;
    assign load_en = xfer_stop && open_q && (|mask_q);
    assign rd_data = vis_q[ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (xfer_stop) begin
            open_q <= 1'b0;
        end else if (xfer_start) begin
            open_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (addr_set) begin
            ptr_q <= (addr_in > LAST_ADDR) ? '0 : addr_in;
        end else if (rd_strobe || wr_take) begin
            ptr_q <= ptr_next(ptr_q);
        end
    end

    for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[i]  <= 1'b0;
                stage_q[i] <= '0;
            end else if (xfer_stop) begin
                mask_q[i]  <= 1'b0;
            end else if (wr_take && (ptr_q == ADDR_W'(i))) begin
                mask_q[i]  <= 1'b1;
                stage_q[i] <= wr_data;
            end
        end
        assign load_val[i] = mask_q[i] ? stage_q[i] : cnt_time[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q <= time_vec_t'(RESET_TIME);
        end else if (load_en) begin
            vis_q <= load_val;
        end else if (!open_q) begin
            vis_q <= cnt_time;
        end
    end
endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
    import rtc_snap_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       xfer_start,
    input  logic       xfer_stop,
    input  logic       addr_set,
    input  logic [2:0] addr_in,
    input  logic       rd_strobe,
    input  logic       wr_strobe,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    logic              sec_pulse;
    logic              phase_zero;
    logic              load_en;
    time_vec_t         load_val;
    time_vec_t         cnt_time;
    time_vec_t         vis_time;
    logic              open_q;
    logic [ADDR_W-1:0] ptr_q;

    rtc_snap_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .clear     (load_en),
        .sec_pulse (sec_pulse),
        .phase_zero(phase_zero)
    );

    rtc_snap_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sec_pulse(sec_pulse),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_q    (cnt_time)
    );

    rtc_snap_regport u_port (
        .clk       (clk),
        .rst       (rst),
        .xfer_start(xfer_start),
        .xfer_stop (xfer_stop),
        .addr_set  (addr_set),
        .addr_in   (addr_in),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .cnt_time  (cnt_time),
        .rd_data   (rd_data),
        .load_en   (load_en),
        .load_val  (load_val),
        .vis_q     (vis_time),
        .open_q    (open_q),
        .ptr_q     (ptr_q)
    );
endmodule

// File: rtl/rtc_snap_checker.sv
module rtc_snap_checker
    import rtc_snap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              open_q,
    input logic              xfer_stop,
    input logic              rd_strobe,
    input logic              addr_set,
    input logic              load_en,
    input logic              phase_zero,
    input logic [ADDR_W-1:0] ptr_q,
    input time_vec_t         vis_time,
    input time_vec_t         cnt_time
);
    assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        open_q && !xfer_stop |=> $stable(vis_time));

    assert_track_R3: assert property (@(posedge clk) disable iff (rst)
        !open_q |=> vis_time == $past(cnt_time));

    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST_ADDR);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && !addr_set |=>
            ptr_q == (($past(ptr_q) == LAST_ADDR) ? '0 : $past(ptr_q) + 1'b1));

    assert_sec_bcd_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_time[0] <= 8'h59 && cnt_time[0][3:0] <= 4'd9);

    assert_commit_copies_R7: assert property (@(posedge clk) disable iff (rst)
        load_en |=> vis_time == cnt_time);

    assert_phase_restart_R8: assert property (@(posedge clk) disable iff (rst)
        load_en |=> phase_zero);
endmodule

bind rtc_snap_top rtc_snap_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .open_q    (open_q),
    .xfer_stop (xfer_stop),
    .rd_strobe (rd_strobe),
    .addr_set  (addr_set),
    .load_en   (load_en),
    .phase_zero(phase_zero),
    .ptr_q     (ptr_q),
    .vis_time  (vis_time),
    .cnt_time  (cnt_time)
);

// File: tb/rtc_snap_top_bench.sv
`timescale 1ns/1ps
module rtc_snap_top_bench;
    localparam int PRESCALE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       xfer_start = 1'b0;
    logic       xfer_stop = 1'b0;
    logic       addr_set = 1'b0;
    logic [2:0] addr_in = '0;
    logic       rd_strobe = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtc_snap_top #(.PRESCALE(PRESCALE)) u_rtc_snap_top (
        .clk(clk), .rst(rst), .osc_tick(osc_tick),
        .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .addr_set(addr_set), .addr_in(addr_in),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    typedef logic [6:0][7:0] tv_t;

    function automatic tv_t mk(logic [7:0] s, mi, h, wd, d, mo, y);
        return {y, mo, d, wd, h, mi, s};
    endfunction

    task automatic check8(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Every task starts just after a falling edge and ends on one.
    task automatic bus_start();
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    endtask
    task automatic bus_stop();
        xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0;
    endtask
    task automatic set_addr(input logic [2:0] a);
        addr_set = 1'b1; addr_in = a; @(negedge clk); addr_set = 1'b0;
    endtask
    task automatic rd(output logic [7:0] b);
        b = rd_data; rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    endtask
    task automatic wr(input logic [7:0] b);
        wr_data = b; wr_strobe = 1'b1; @(negedge clk); wr_strobe = 1'b0;
    endtask
    task automatic osc(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic write_time(input tv_t t);
        bus_start(); set_addr(3'd0);
        for (int i = 0; i < 7; i++) wr(t[i]);
        bus_stop();
    endtask

    task automatic read_time(output tv_t t);
        bus_start(); set_addr(3'd0);
        for (int i = 0; i < 7; i++) rd(t[i]);
        bus_stop();
    endtask

    task automatic expect_time(input string tag, input tv_t exp);
        tv_t got;
        read_time(got);
        for (int i = 0; i < 7; i++) check8(tag, $sformatf("field %0d", i), got[i], exp[i]);
    endtask

    task automatic t_reset_R1();
        expect_time("R1", mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
    endtask

    task automatic t_rollover_R6();
        write_time(mk(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23));
        osc(PRESCALE);
        expect_time("R6", mk(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23));
        osc(PRESCALE);
        expect_time("R6/R9", mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23));
    endtask

    task automatic t_calendar_R9();
        write_time(mk(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24));
        osc(PRESCALE);
        expect_time("R9 leap", mk(8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24));
        write_time(mk(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h00));
        osc(PRESCALE);
        expect_time("R9 year00", mk(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h00));
        write_time(mk(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h31));
        osc(PRESCALE);
        expect_time("R9 april", mk(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h05, 8'h31));
        write_time(mk(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99));
        osc(PRESCALE);
        expect_time("R9 century", mk(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 8'h00));
    endtask

    task automatic t_freeze_R2_R7();
        logic [7:0] b;
        write_time(mk(8'h59, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
        bus_start(); set_addr(3'd0);
        rd(b); check8("R2", "seconds before tick", b, 8'h59);
        osc(PRESCALE);
        rd(b); check8("R2", "minutes after tick", b, 8'h00);
        set_addr(3'd0);
        rd(b); check8("R2", "seconds reread", b, 8'h59);
        bus_stop();
        expect_time("R7", mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
    endtask

    task automatic t_phase_R8();
        logic [7:0] b;
        osc(2); // move the phase away from zero before the commit
        write_time(mk(8'h10, 8'h20, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30));
        osc(PRESCALE - 1);
        bus_start(); set_addr(3'd0); rd(b); bus_stop();
        check8("R8", "no second before full period", b, 8'h10);
        osc(1);
        bus_start(); set_addr(3'd0); rd(b); bus_stop();
        check8("R8", "second after full period", b, 8'h11);
    endtask

    task automatic t_partial_R10();
        write_time(mk(8'h11, 8'h22, 8'h13, 8'h05, 8'h17, 8'h08, 8'h41));
        bus_start(); set_addr(3'd1); wr(8'h30); wr(8'h07); bus_stop();
        expect_time("R10", mk(8'h11, 8'h30, 8'h07, 8'h05, 8'h17, 8'h08, 8'h41));
    endtask

    task automatic t_ignored_R4();
        logic [7:0] b;
        set_addr(3'd2);
        wr(8'h42);
        bus_start();
        rd(b); check8("R4", "pointer kept, hours unchanged", b, 8'h07);
        bus_stop();
        expect_time("R4", mk(8'h11, 8'h30, 8'h07, 8'h05, 8'h17, 8'h08, 8'h41));
    endtask

    task automatic t_staged_R11();
        logic [7:0] b;
        bus_start(); set_addr(3'd0); wr(8'h45);
        set_addr(3'd0); rd(b);
        check8("R11", "read during write", b, 8'h11);
        bus_stop();
        bus_start(); set_addr(3'd0); rd(b); bus_stop();
        check8("R11", "committed seconds", b, 8'h45);
    endtask

    task automatic t_pointer_R5();
        logic [7:0] b;
        bus_start(); set_addr(3'd6);
        rd(b); check8("R5", "address 6 is year", b, 8'h41);
        rd(b); check8("R5", "wrap to seconds", b, 8'h45);
        rd(b); check8("R5", "then minutes", b, 8'h30);
        set_addr(3'd7);
        rd(b); check8("R5", "address 7 maps to 0", b, 8'h45);
        set_addr(3'd4);
        rd(b); check8("R5", "address 4 is date", b, 8'h17);
        bus_stop();
    endtask

    task automatic t_between_R3();
        logic [7:0] b;
        write_time(mk(8'h59, 8'h09, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
        bus_start(); set_addr(3'd1); rd(b); bus_stop();
        check8("R3", "minutes first transaction", b, 8'h09);
        osc(PRESCALE);
        bus_start(); set_addr(3'd0); rd(b); bus_stop();
        check8("R3", "seconds after rollover", b, 8'h00);
        bus_start(); set_addr(3'd1); rd(b); bus_stop();
        check8("R3", "minutes second transaction", b, 8'h10);
    endtask

    initial begin
        #500us;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_R1();
        t_rollover_R6();
        t_calendar_R9();
        t_freeze_R2_R7();
        t_phase_R8();
        t_partial_R10();
        t_ignored_R4();
        t_staged_R11();
        t_pointer_R5();
        t_between_R3();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule